// File: doc/BRIEF.md
# Serial Programming Command Engine

This block is the target-side decoder of a two-wire in-circuit programming port. A host drives a programming clock and a data line. Every transaction is a 4-bit command and then a 16-bit payload, both least significant bit first. The engine samples the two wires with its own system clock and keeps a byte address pointer. It collects 16-bit payloads into an 8-byte row buffer, and it can commit that row to an on-block memory array model or erase the whole array.

The host times the write pulse itself. After a start-programming command, the host sends a NOP and holds the fourth clock of that NOP high. The program strobe stays active for exactly as long as that clock is high. When the clock drops, the strobe ends and a discharge interval begins. The clock must then stay low for a set number of system cycles before any further clock edge is decoded. A bulk erase is requested by writing a key byte to a fixed register address, followed by a NOP. The engine then runs its own erase timer before it reports completion.

Top module: `serprog_engine`

## Requirements
- R1: Bits are taken on each falling edge of `pgc` (after synchronisation), least significant bit first. The first 4 bits form the command and the next 16 bits form the payload, giving 20 bits per frame.
- R2: Command 4'h1 loads pointer bits [15:0] from the payload. Command 4'h2 loads pointer bits [23:16] from payload bits [7:0].
- R3: Command 4'h3 stores payload[7:0] in buffer byte {ptr[2:1],0} and payload[15:8] in the byte after it. It then adds 2 to ptr[2:0], wrapping within the 8-byte row, and leaves ptr[23:3] unchanged.
- R4: Command 4'hF is accepted when the buffer holds at least one load and ptr[23:3] equals the row of the last load. After acceptance, the fourth clock of the next frame raises `prog_en` for as long as `pgc` stays high. While `prog_en` is high, `prog_addr` is {row,3'b000} and `prog_data` is the buffer, with byte k in bits [8k+7:8k]. That array row (row mod 16) takes the buffer value.
- R5: When `pgc` falls to end the strobe, `dis_busy` rises. It stays high until `pgc` has been low for 16 consecutive system cycles, and any high level on `pgc` restarts the count. `pgc` edges seen while busy are not decoded.
- R6: A command 4'hF that fails the row check, or that finds the buffer empty, sets `seq_err`. No strobe follows and no array row changes. The next accepted 4'hF clears `seq_err`.
- R7: Command 4'h4 with the pointer at 24'h3C0004 and payload[7:0] = 8'h80, followed by a complete NOP frame (4'h0), holds `erase_busy` high for 64 cycles. After that every array row reads all ones. Any other key value starts no erase.
- R8: Any command code other than 4'h0-4'h4 and 4'hF is ignored. Its payload leaves both the buffer and the pointer unchanged.
- R9: Starting a strobe empties the buffer and sets every byte of it to 8'hFF. Bytes that are not loaded before the next commit are therefore written as 8'hFF.
- R10: After reset, `prog_en`, `dis_busy`, `erase_busy` and `seq_err` are low, and every array row reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pgc | input | 1 | Programming clock from the host (asynchronous) |
| pgd | input | 1 | Programming data from the host (asynchronous) |
| rd_row | input | 4 | Row index for the array observation port |
| prog_en | output | 1 | Program strobe, high for the duration of the host-held clock |
| prog_addr | output | 24 | Byte address of the row being programmed |
| prog_data | output | 64 | Row data being programmed |
| dis_busy | output | 1 | Discharge interval running |
| erase_busy | output | 1 | Bulk erase timer running |
| seq_err | output | 1 | Last start-programming request was refused |
| rd_data | output | 64 | Contents of array row `rd_row` |

## Verification
Two functions can land on the same system cycle. The falling clock edge that ends the program strobe is also the fourth command bit of the NOP frame, so frame counting and the start of the discharge interval happen together. A fault in either one throws off the framing of every later transaction. The bench provokes a second overlap by pulsing `pgc` in the middle of the discharge interval. It then checks that `dis_busy` is still high after the original interval would have expired, and that all later frames still decode and commit to the expected rows.

// File: rtl/serprog_pkg.sv
package serprog_pkg;
   localparam int CMD_W      = 4;
   localparam int PAY_W      = 16;
   localparam int FRAME_BITS = CMD_W + PAY_W;
   localparam int CNT_W      = $clog2(FRAME_BITS);

   localparam logic [CMD_W-1:0] OP_NOP    = 4'h0;
   localparam logic [CMD_W-1:0] OP_PTR_LO = 4'h1;
   localparam logic [CMD_W-1:0] OP_PTR_HI = 4'h2;
   localparam logic [CMD_W-1:0] OP_LOAD   = 4'h3;
   localparam logic [CMD_W-1:0] OP_REGWR  = 4'h4;
   localparam logic [CMD_W-1:0] OP_PROG   = 4'hF;
endpackage

// File: rtl/serprog_sync.sv
module serprog_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pgc,
   input  logic pgd,
   output logic pgc_s,
   output logic pgd_s,
   output logic pgc_fall
);
   logic [STAGES-1:0] c_ff;
   logic [STAGES-1:0] d_ff;
   logic              c_last;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               c_ff[0] <= 1'b0;
               d_ff[0] <= 1'b0;
            end else begin
               c_ff[0] <= pgc;
               d_ff[0] <= pgd;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               c_ff[s] <= 1'b0;
               d_ff[s] <= 1'b0;
            end else begin
               c_ff[s] <= c_ff[s-1];
               d_ff[s] <= d_ff[s-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) c_last <= 1'b0;
      else        c_last <= c_ff[STAGES-1];
   end

   assign pgc_s    = c_ff[STAGES-1];
   assign pgd_s    = d_ff[STAGES-1];
   assign pgc_fall = c_last & ~c_ff[STAGES-1];
endmodule

// File: rtl/serprog_frame.sv
module serprog_frame
   import serprog_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_stb,
   input  logic             bit_val,
   output logic [CNT_W-1:0] bit_cnt,
   output logic [CMD_W-1:0] cmd,
   output logic [PAY_W-1:0] payload,
   output logic             cmd_done,
   output logic             frame_done
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt    <= '0;
         cmd        <= '0;
         payload    <= '0;
         cmd_done   <= 1'b0;
         frame_done <= 1'b0;
      end else begin
         cmd_done   <= 1'b0;
         frame_done <= 1'b0;
         if (bit_stb) begin
            if (bit_cnt < CNT_W'(CMD_W)) begin
               cmd <= {bit_val, cmd[CMD_W-1:1]};
               if (bit_cnt == CNT_W'(CMD_W-1)) cmd_done <= 1'b1;
            end else begin
               payload <= {bit_val, payload[PAY_W-1:1]};
            end
            if (bit_cnt == CNT_W'(FRAME_BITS-1)) begin
               bit_cnt    <= '0;
               frame_done <= 1'b1;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/serprog_wbuf.sv
module serprog_wbuf #(
   parameter int BYTES = 8,
   localparam int OFS_W = $clog2(BYTES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [OFS_W-1:0]   wr_ofs,
   input  logic [15:0]        wr_data,
   input  logic               clr,
   output logic [8*BYTES-1:0] row
);
   logic [OFS_W-1:0] lo_ofs;
   logic [OFS_W-1:0] hi_ofs;

   assign lo_ofs = {wr_ofs[OFS_W-1:1], 1'b0};
   assign hi_ofs = {wr_ofs[OFS_W-1:1], 1'b1};

   for (genvar i = 0; i < BYTES; i++) begin : g_lane
      logic [7:0] q;
      logic       hit;
      logic [7:0] src;
      if (i % 2 == 0) begin : g_even
         assign hit = wr_en && (lo_ofs == OFS_W'(i));
         assign src = wr_data[7:0];
      end else begin : g_odd
         assign hit = wr_en && (hi_ofs == OFS_W'(i));
         assign src = wr_data[15:8];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   q <= 8'hFF;
         else if (clr) q <= 8'hFF;
         else if (hit) q <= src;
      end
      assign row[8*i +: 8] = q;
   end
endmodule

// File: rtl/serprog_array.sv
module serprog_array #(
   parameter int ROWS     = 16,
   parameter int ROW_BITS = 64,
   localparam int IDX_W   = $clog2(ROWS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [ROW_BITS-1:0] wr_data,
   input  logic                clr_all,
   input  logic [IDX_W-1:0]    rd_idx,
   output logic [ROW_BITS-1:0] rd_data
);
   logic [ROW_BITS-1:0] cells [ROWS];

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic [ROW_BITS-1:0] m;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  m <= '1;
         else if (clr_all)                            m <= '1;
         else if (wr_en && wr_idx == IDX_W'(r))       m <= wr_data;
      end
      assign cells[r] = m;
   end

   assign rd_data = cells[rd_idx];
endmodule

// File: rtl/serprog_engine.sv
module serprog_engine
   import serprog_pkg::*;
#(
   parameter int          ADDR_W      = 24,
   parameter int          BUF_BYTES   = 8,
   parameter int          DEPTH_WORDS = 64,
   parameter int          SYNC_STAGES = 2,
   parameter int          DISCH_CYC   = 16,
   parameter int          ERASE_CYC   = 64,
   parameter logic [31:0] ERASE_REG   = 32'h003C_0004,
   parameter logic [7:0]  ERASE_KEY   = 8'h80,
   localparam int OFS_W     = $clog2(BUF_BYTES),
   localparam int ROW_BITS  = 8 * BUF_BYTES,
   localparam int ROW_WORDS = BUF_BYTES / 2,
   localparam int ROWS      = DEPTH_WORDS / ROW_WORDS,
   localparam int IDX_W     = $clog2(ROWS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pgc,
   input  logic                pgd,
   input  logic [IDX_W-1:0]    rd_row,
   output logic                prog_en,
   output logic [ADDR_W-1:0]   prog_addr,
   output logic [ROW_BITS-1:0] prog_data,
   output logic                dis_busy,
   output logic                erase_busy,
   output logic                seq_err,
   output logic [ROW_BITS-1:0] rd_data
);
   localparam int ROW_W = ADDR_W - OFS_W;
   localparam int DC_W  = $clog2(DISCH_CYC + 1);
   localparam int EC_W  = $clog2(ERASE_CYC + 1);

   if (BUF_BYTES < 2 || (1 << OFS_W) != BUF_BYTES) begin : g_bad_buf
      $error("BUF_BYTES must be a power of two of at least 2");
   end
   if (ADDR_W < 17 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must lie between 17 and 32");
   end
   if (DEPTH_WORDS % ROW_WORDS != 0 || ROWS < 2 || (1 << IDX_W) != ROWS) begin : g_bad_depth
      $error("DEPTH_WORDS must give a power-of-two row count");
   end
   if (DISCH_CYC < 1 || ERASE_CYC < 2 || SYNC_STAGES < 2) begin : g_bad_time
      $error("timing parameters out of range");
   end

   logic             pgc_s, pgd_s, pgc_fall;
   logic             bit_stb;
   logic [CNT_W-1:0] bit_cnt;
   logic [CMD_W-1:0] cmd;
   logic [PAY_W-1:0] payload;
   logic             cmd_done, frame_done;

   logic [ADDR_W-1:0]   ptr;
   logic [ROW_W-1:0]    ptr_row;
   logic [ROW_W-1:0]    load_row;
   logic                buf_loaded;
   logic                armed;
   logic                pulse_q;
   logic                pulse_start, pulse_end;
   logic                erase_armed;
   logic [DC_W-1:0]     dc_cnt;
   logic [EC_W-1:0]     ec_cnt;
   logic [ROW_BITS-1:0] buf_row;
   logic [OFS_W-1:0]    next_ofs;
   logic                busy;
   logic                do_load;

   serprog_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pgc(pgc), .pgd(pgd),
      .pgc_s(pgc_s), .pgd_s(pgd_s), .pgc_fall(pgc_fall)
   );

   assign busy    = (dc_cnt != '0) || (ec_cnt != '0);
   assign bit_stb = pgc_fall && !busy;

   serprog_frame u_frame (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(pgd_s),
      .bit_cnt(bit_cnt), .cmd(cmd), .payload(payload),
      .cmd_done(cmd_done), .frame_done(frame_done)
   );

   assign ptr_row  = ptr[ADDR_W-1:OFS_W];
   assign next_ofs = {ptr[OFS_W-1:1], 1'b0} + OFS_W'(2);
   assign do_load  = frame_done && (cmd == OP_LOAD);

   assign pulse_start = armed && !pulse_q && pgc_s && !busy &&
                        (bit_cnt == CNT_W'(CMD_W-1));
   assign pulse_end   = pulse_q && pgc_fall;

   serprog_wbuf #(.BYTES(BUF_BYTES)) u_wbuf (
      .clk(clk), .rst_n(rst_n), .wr_en(do_load), .wr_ofs(ptr[OFS_W-1:0]),
      .wr_data(payload), .clr(pulse_start), .row(buf_row)
   );

   serprog_array #(.ROWS(ROWS), .ROW_BITS(ROW_BITS)) u_array (
      .clk(clk), .rst_n(rst_n), .wr_en(pulse_start),
      .wr_idx(load_row[IDX_W-1:0]), .wr_data(buf_row),
      .clr_all(ec_cnt == EC_W'(1)), .rd_idx(rd_row), .rd_data(rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr         <= '0;
         load_row    <= '0;
         buf_loaded  <= 1'b0;
         armed       <= 1'b0;
         seq_err     <= 1'b0;
         pulse_q     <= 1'b0;
         prog_addr   <= '0;
         prog_data   <= '0;
         erase_armed <= 1'b0;
         dc_cnt      <= '0;
         ec_cnt      <= '0;
      end else begin
         if (frame_done) begin
            case (cmd)
               OP_PTR_LO: ptr[15:0] <= payload;
               OP_PTR_HI: ptr[ADDR_W-1:16] <= payload[ADDR_W-17:0];
               OP_LOAD: begin
                  ptr[OFS_W-1:0] <= next_ofs;
                  load_row       <= ptr_row;
                  buf_loaded     <= 1'b1;
               end
               default: ;
            endcase
            erase_armed <= (cmd == OP_REGWR) &&
                           (ptr == ERASE_REG[ADDR_W-1:0]) &&
                           (payload[7:0] == ERASE_KEY);
         end

         if (frame_done && cmd == OP_NOP && erase_armed)
            ec_cnt <= EC_W'(ERASE_CYC);
         else if (ec_cnt != '0)
            ec_cnt <= ec_cnt - 1'b1;

         if (cmd_done && cmd == OP_PROG) begin
            if (buf_loaded && ptr_row == load_row) begin
               armed   <= 1'b1;
               seq_err <= 1'b0;
            end else begin
               armed   <= 1'b0;
               seq_err <= 1'b1;
            end
         end

         if (pulse_start) begin
            pulse_q    <= 1'b1;
            prog_addr  <= {load_row, {OFS_W{1'b0}}};
            prog_data  <= buf_row;
            buf_loaded <= 1'b0;
         end
         if (pulse_end) begin
            pulse_q <= 1'b0;
            armed   <= 1'b0;
         end

         if (pulse_end)
            dc_cnt <= DC_W'(DISCH_CYC);
         else if (dc_cnt != '0)
            dc_cnt <= pgc_s ? DC_W'(DISCH_CYC) : dc_cnt - 1'b1;
      end
   end

   assign prog_en    = pulse_q;
   assign dis_busy   = (dc_cnt != '0);
   assign erase_busy = (ec_cnt != '0);
endmodule

// File: rtl/serprog_engine_chk.sv
module serprog_engine_chk #(
   parameter int ADDR_W   = 24,
   parameter int ROW_BITS = 64
) (
   input logic                clk,
   input logic                rst_n,
   input logic                prog_en,
   input logic [ADDR_W-1:0]   prog_addr,
   input logic [ROW_BITS-1:0] prog_data,
   input logic                dis_busy,
   input logic                erase_busy,
   input logic                seq_err
);
   a_r4_strobe_target_held: assert property (@(posedge clk) disable iff (!rst_n)
      prog_en && $past(prog_en) |-> $stable(prog_addr) && $stable(prog_data));

   a_r5_discharge_follows: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prog_en) |-> dis_busy);

   a_r5_no_strobe_in_discharge: assert property (@(posedge clk) disable iff (!rst_n)
      dis_busy |-> !prog_en);

   a_r6_refused_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_err) |-> !prog_en);

   a_r7_erase_excludes_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      erase_busy |-> !prog_en);

   a_r5_strobe_starts_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_en) |-> !$past(dis_busy));
endmodule

bind serprog_engine serprog_engine_chk #(.ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_addr(prog_addr),
   .prog_data(prog_data), .dis_busy(dis_busy), .erase_busy(erase_busy),
   .seq_err(seq_err)
);

// File: tb/sim_serprog_engine.sv
module sim_serprog_engine;
   localparam int HALF  = 8;
   localparam int DISCH = 16;
   localparam int ERASE = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pgc = 1'b0;
   logic        pgd = 1'b0;
   logic [3:0]  rd_row = '0;
   logic        prog_en, dis_busy, erase_busy, seq_err;
   logic [23:0] prog_addr;
   logic [63:0] prog_data, rd_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      string       req;
      logic [23:0] addr;
      logic [63:0] data;
   } exp_t;
   exp_t sb[$];

   always #2 clk = ~clk;

   serprog_engine u0 (
      .clk(clk), .rst_n(rst_n), .pgc(pgc), .pgd(pgd), .rd_row(rd_row),
      .prog_en(prog_en), .prog_addr(prog_addr), .prog_data(prog_data),
      .dis_busy(dis_busy), .erase_busy(erase_busy), .seq_err(seq_err),
      .rd_data(rd_data)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: every strobe start must match the next scoreboard entry
   logic pe_prev = 1'b0;
   always @(negedge clk) begin
      if (prog_en === 1'b1 && pe_prev == 1'b0) begin
         if (sb.size() == 0) begin
            chk("R4 unexpected strobe", {40'd0, prog_addr}, 64'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk({e.req, " addr"}, {40'd0, prog_addr}, {40'd0, e.addr});
            chk({e.req, " data"}, prog_data, e.data);
         end
      end
      pe_prev = (prog_en === 1'b1);
   end

   task automatic send_bit(input logic b);
      pgd = b;
      pgc = 1'b1;
      repeat (HALF) @(negedge clk);
      pgc = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic send_frame(input logic [3:0] c, input logic [15:0] p);
      for (int i = 0; i < 4; i++)  send_bit(c[i]);
      for (int i = 0; i < 16; i++) send_bit(p[i]);
   endtask

   task automatic set_ptr(input logic [23:0] a);
      send_frame(4'h2, {8'h00, a[23:16]});
      send_frame(4'h1, a[15:0]);
   endtask

   task automatic expect_commit(input string req, input logic [23:0] a, input logic [63:0] d);
      exp_t e;
      e.req = req; e.addr = a; e.data = d;
      sb.push_back(e);
   endtask

   task automatic row_is(input int idx, input logic [63:0] exp, input string req);
      rd_row = 4'(idx);
      @(negedge clk);
      chk(req, rd_data, exp);
   endtask

   // NOP whose fourth clock is held high for 'hold' cycles
   task automatic prog_nop(input int hold, input logic pulse_exp, input string req);
      for (int i = 0; i < 3; i++) send_bit(1'b0);
      pgd = 1'b0;
      pgc = 1'b1;
      repeat (hold / 2) @(negedge clk);
      chk({req, " strobe level"}, {63'd0, prog_en}, {63'd0, pulse_exp});
      repeat (hold - hold / 2) @(negedge clk);
      pgc = 1'b0;
      repeat (6) @(negedge clk);
      chk({req, " R5 discharge after strobe"}, {63'd0, dis_busy}, {63'd0, pulse_exp});
      repeat (DISCH + 10) @(negedge clk);
      chk({req, " R5 discharge over"}, {63'd0, dis_busy}, 64'd0);
      for (int i = 0; i < 16; i++) send_bit(1'b0);
   endtask

   initial begin
      repeat (150000) @(negedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      // R10 reset state
      chk("R10 prog_en", {63'd0, prog_en}, 64'd0);
      chk("R10 dis_busy", {63'd0, dis_busy}, 64'd0);
      chk("R10 erase_busy", {63'd0, erase_busy}, 64'd0);
      chk("R10 seq_err", {63'd0, seq_err}, 64'd0);
      row_is(2, '1, "R10 array reset");
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1 R3 R4: full row at byte address 0x10 (row 2)
      set_ptr(24'h000010);
      send_frame(4'h3, 16'h1111);
      send_frame(4'h3, 16'h2222);
      send_frame(4'h3, 16'h3333);
      send_frame(4'h3, 16'h4444);
      send_frame(4'hF, 16'h0000);
      chk("R4 accepted", {63'd0, seq_err}, 64'd0);
      expect_commit("R1 R4 row2", 24'h000010, 64'h4444_3333_2222_1111);
      prog_nop(30, 1'b1, "R4 row2");
      row_is(2, 64'h4444_3333_2222_1111, "R4 array row2");

      // R9: single load after a commit, remaining bytes 8'hFF
      set_ptr(24'h000018);
      send_frame(4'h3, 16'hA55A);
      send_frame(4'hF, 16'h0000);
      expect_commit("R9 row3", 24'h000018, 64'hFFFF_FFFF_FFFF_A55A);
      prog_nop(24, 1'b1, "R9 row3");
      row_is(3, 64'hFFFF_FFFF_FFFF_A55A, "R9 array row3");

      // R6: empty buffer is refused
      send_frame(4'hF, 16'h0000);
      chk("R6 empty buffer err", {63'd0, seq_err}, 64'd1);
      prog_nop(24, 1'b0, "R6 empty");

      // R6: row mismatch refused, then accepted after the pointer returns
      set_ptr(24'h000020);
      send_frame(4'h3, 16'hBEEF);
      set_ptr(24'h000028);
      send_frame(4'hF, 16'h0000);
      chk("R6 mismatch err", {63'd0, seq_err}, 64'd1);
      prog_nop(24, 1'b0, "R6 mismatch");
      row_is(5, '1, "R6 row5 untouched");
      row_is(4, '1, "R6 row4 untouched");
      set_ptr(24'h000022);
      send_frame(4'hF, 16'h0000);
      chk("R6 err cleared", {63'd0, seq_err}, 64'd0);
      expect_commit("R6 row4", 24'h000020, 64'hFFFF_FFFF_FFFF_BEEF);
      prog_nop(24, 1'b1, "R6 row4");

      // R8: unknown command leaves pointer and buffer alone
      set_ptr(24'h000030);
      send_frame(4'h3, 16'h0A0A);
      send_frame(4'h7, 16'h5555);
      send_frame(4'h3, 16'h0B0B);
      send_frame(4'hF, 16'h0000);
      expect_commit("R8 row6", 24'h000030, 64'hFFFF_FFFF_0B0B_0A0A);
      prog_nop(24, 1'b1, "R8 row6");
      row_is(6, 64'hFFFF_FFFF_0B0B_0A0A, "R8 array row6");

      // R3: offset wraps within the row
      set_ptr(24'h00003E);
      send_frame(4'h3, 16'hC1C1);
      send_frame(4'h3, 16'hD2D2);
      send_frame(4'hF, 16'h0000);
      expect_commit("R3 row7 wrap", 24'h000038, 64'hC1C1_FFFF_FFFF_D2D2);
      prog_nop(24, 1'b1, "R3 row7");

      // R2 and R5: upper pointer bits, clock pulse during discharge
      set_ptr(24'h010008);
      send_frame(4'h3, 16'h7777);
      send_frame(4'hF, 16'h0000);
      expect_commit("R2 high pointer", 24'h010008, 64'hFFFF_FFFF_FFFF_7777);
      for (int i = 0; i < 3; i++) send_bit(1'b0);
      pgd = 1'b0;
      pgc = 1'b1;
      repeat (24) @(negedge clk);
      pgc = 1'b0;
      repeat (10) @(negedge clk);
      pgc = 1'b1;
      repeat (3) @(negedge clk);
      pgc = 1'b0;
      repeat (12) @(negedge clk);
      chk("R5 restart by clock pulse", {63'd0, dis_busy}, 64'd1);
      repeat (30) @(negedge clk);
      chk("R5 discharge ends", {63'd0, dis_busy}, 64'd0);
      for (int i = 0; i < 16; i++) send_bit(1'b0);
      row_is(1, 64'hFFFF_FFFF_FFFF_7777, "R2 array row1");

      // R7: wrong key, then correct key
      set_ptr(24'h3C0004);
      send_frame(4'h4, 16'h0081);
      send_frame(4'h0, 16'h0000);
      chk("R7 wrong key no erase", {63'd0, erase_busy}, 64'd0);
      repeat (ERASE + 10) @(negedge clk);
      row_is(1, 64'hFFFF_FFFF_FFFF_7777, "R7 wrong key keeps row1");
      send_frame(4'h4, 16'h0080);
      send_frame(4'h0, 16'h0000);
      chk("R7 erase running", {63'd0, erase_busy}, 64'd1);
      repeat (ERASE + 10) @(negedge clk);
      chk("R7 erase finished", {63'd0, erase_busy}, 64'd0);
      row_is(1, '1, "R7 row1 erased");
      row_is(2, '1, "R7 row2 erased");

      chk("R4 scoreboard drained", 64'(sb.size()), 64'd0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule